// File: doc/BRIEF.md
# Multi-Program Wash Cycle Sequencer

This block steps a washer through one of three wash programs (basic, normal, heavy). The programs have different lengths and share a single state graph. It waits in an idle state until the lid is seen to close. At that moment payment must already be satisfied and exactly one program switch must be set. The lid is then locked, and for one clock the display is told to show two fixed identification digits. After that the block walks through the program's task steps, one per period of the slow synchronizing clock. During the steps it reports the current task on a 3-bit LED code and tells the display to show the program's two-letter mnemonic.

When the last step ends, the lock drops and the block is back in its initial state. In that state the LED code is zero and the display shows the money count, which reads "00" once the external coin logic has cleared. Coin counting and seven-segment decoding sit outside this block. It only selects what the two-digit driver shows, and it supplies the identification digits.

Top module: `wash_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it, task_code is 000, lid_lock is 0, disp_sel is 00 (money), prog_id is 00 and both digit outputs are 0.
- R2: A program starts only on a clock edge where lid_closed is 1 and was 0 at the previous edge, paid is 1, and prog_sel is exactly one of 001 (basic), 010 (normal) or 100 (heavy). Any other combination leaves the block idle.
- R3: In the cycle after a start, disp_sel is 01 (identification), fp_tens and fp_ones equal the FP_TENS and FP_ONES parameters, task_code is 000, lid_lock is 1, and prog_id gives the program (01 basic, 10 normal, 11 heavy). This lasts exactly one cycle.
- R4: The basic program shows task codes 001, 010, 100, 101 on successive cycles. The codes mean: 001 wash with detergent, 010 wash with spin, 011 rinse with softener, 100 rinse with spin, 101 spin only.
- R5: The normal program shows task codes 001, 010, 011, 100, 101 on successive cycles.
- R6: The heavy program shows task codes 001, 010, 001, 010, 011, 100, 101 on successive cycles.
- R7: During every task step disp_sel is 10 (mnemonic) and prog_id names the running program.
- R8: lid_lock is 1 from the identification cycle through the final spin step. In the cycle after the spin step the block is idle with all outputs as in R1.
- R9: Once a program has started, changes on prog_sel, paid and lid_closed do not alter the step sequence, prog_id or lid_lock.
- R10: After a program completes, the block does not restart while the lid stays closed, even with paid high and a valid selection. A new run needs the lid to open and close again.
- R11: fp_tens and fp_ones are 0 in every cycle other than the identification cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow synchronizing clock; one task step per period |
| rst | input | 1 | Synchronous active-high reset to idle |
| prog_sel | input | 3 | Program switches: bit 0 basic, bit 1 normal, bit 2 heavy |
| lid_closed | input | 1 | Lid sensor, 1 when closed |
| paid | input | 1 | Payment for the selected program has been met |
| task_code | output | 3 | Current task for the LEDs (000 idle or identification) |
| lid_lock | output | 1 | Lid locked while a program runs |
| disp_sel | output | 2 | Display source: 00 money, 01 identification digits, 10 mnemonic |
| prog_id | output | 2 | Running program: 00 none, 01 basic, 10 normal, 11 heavy |
| fp_tens | output | 4 | Left identification digit, valid in the identification cycle |
| fp_ones | output | 4 | Right identification digit, valid in the identification cycle |

## Verification
The hardest situation to reach from the ports is a lid that reopens and closes again while a program is running. From the ports this looks like a fresh closing edge, but the block must ignore it. A second hard case is a lid that simply stays shut after completion with a valid, paid selection still present, where the block must stay idle. The bench sweeps all eight switch patterns with payment both low and high. In every run it drops the lid input on the second step and raises it again on the third, scrambles the switches and the payment flag on every step, and then holds the lid closed with a valid paid request for several cycles after the final spin.

// File: rtl/wash_pkg.sv
package wash_pkg;

   typedef enum logic [2:0] {
      TK_NONE       = 3'd0,
      TK_WASH_DET   = 3'd1,
      TK_WASH_SPIN  = 3'd2,
      TK_RINSE_SOFT = 3'd3,
      TK_RINSE_SPIN = 3'd4,
      TK_SPIN       = 3'd5
   } task_e;

   typedef enum logic [1:0] {
      PG_NONE   = 2'd0,
      PG_BASIC  = 2'd1,
      PG_NORMAL = 2'd2,
      PG_HEAVY  = 2'd3
   } prog_e;

   typedef enum logic [1:0] {
      DS_MONEY    = 2'd0,
      DS_PRINT    = 2'd1,
      DS_MNEMONIC = 2'd2
   } disp_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PRINT = 2'd1,
      ST_RUN   = 2'd2
   } phase_e;

   localparam int MAX_STEPS = 7;

   // number of wash pairs (detergent then spin) at the head of a program
   function automatic int wash_pairs(prog_e p);
      case (p)
         PG_HEAVY:  return 2;
         PG_BASIC,
         PG_NORMAL: return 1;
         default:   return 0;
      endcase
   endfunction

   // whether a softener rinse precedes the spin rinse
   function automatic bit has_softener(prog_e p);
      return (p == PG_NORMAL) || (p == PG_HEAVY);
   endfunction

   function automatic int prog_len(prog_e p);
      if (p == PG_NONE) return 0;
      return 2 * wash_pairs(p) + (has_softener(p) ? 3 : 2);
   endfunction

   function automatic task_e step_task(prog_e p, int k);
      int tail;
      if (p == PG_NONE || k >= prog_len(p)) return TK_NONE;
      if (k < 2 * wash_pairs(p))
         return (k % 2 == 0) ? TK_WASH_DET : TK_WASH_SPIN;
      tail = k - 2 * wash_pairs(p);
      if (!has_softener(p)) tail = tail + 1;
      case (tail)
         0:       return TK_RINSE_SOFT;
         1:       return TK_RINSE_SPIN;
         default: return TK_SPIN;
      endcase
   endfunction

endpackage

// File: rtl/wash_start_detect.sv
module wash_start_detect
   import wash_pkg::*;
#(
   parameter int SEL_W    = 3,
   parameter int SEL_MODE = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] prog_sel,
   input  logic             lid_closed,
   input  logic             paid,
   output logic             start,
   output prog_e            start_prog
);

   logic  lid_q;
   prog_e pick;

   // lid history resets to "closed" so a lid shut through reset cannot start
   always_ff @(posedge clk) begin
      if (rst) lid_q <= 1'b1;
      else     lid_q <= lid_closed;
   end

   generate
      if (SEL_MODE == 0) begin : g_strict
         always_comb begin
            case (prog_sel)
               3'b001:  pick = PG_BASIC;
               3'b010:  pick = PG_NORMAL;
               3'b100:  pick = PG_HEAVY;
               default: pick = PG_NONE;
            endcase
         end
      end else begin : g_priority
         always_comb begin
            if (prog_sel[0])      pick = PG_BASIC;
            else if (prog_sel[1]) pick = PG_NORMAL;
            else if (prog_sel[2]) pick = PG_HEAVY;
            else                  pick = PG_NONE;
         end
      end
   endgenerate

   assign start      = lid_closed && !lid_q && paid && (pick != PG_NONE);
   assign start_prog = pick;

endmodule

// File: rtl/wash_step_ctrl.sv
module wash_step_ctrl
   import wash_pkg::*;
#(
   parameter int STEP_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  prog_e             start_prog,
   output phase_e            phase,
   output prog_e             prog,
   output logic [STEP_W-1:0] step
);

   logic last_step;

   assign last_step = (int'(step) >= prog_len(prog) - 1);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= ST_IDLE;
         prog  <= PG_NONE;
         step  <= '0;
      end else begin
         case (phase)
            ST_IDLE: begin
               if (start) begin
                  phase <= ST_PRINT;
                  prog  <= start_prog;
                  step  <= '0;
               end
            end
            ST_PRINT: begin
               phase <= ST_RUN;
            end
            ST_RUN: begin
               if (last_step) begin
                  phase <= ST_IDLE;
                  prog  <= PG_NONE;
                  step  <= '0;
               end else begin
                  step <= step + STEP_W'(1);
               end
            end
            default: begin
               phase <= ST_IDLE;
               prog  <= PG_NONE;
               step  <= '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/wash_out_map.sv
module wash_out_map
   import wash_pkg::*;
#(
   parameter int STEP_W   = 3,
   parameter int DIGIT_W  = 4,
   parameter int FP_TENS  = 3,
   parameter int FP_ONES  = 6
) (
   input  phase_e             phase,
   input  prog_e              prog,
   input  logic [STEP_W-1:0]  step,
   output logic [2:0]         task_code,
   output logic               lid_lock,
   output logic [1:0]         disp_sel,
   output logic [1:0]         prog_id,
   output logic [DIGIT_W-1:0] fp_tens,
   output logic [DIGIT_W-1:0] fp_ones
);

   task_e cur_task;
   disp_e cur_disp;

   always_comb begin
      cur_task = TK_NONE;
      cur_disp = DS_MONEY;
      fp_tens  = '0;
      fp_ones  = '0;
      case (phase)
         ST_PRINT: begin
            cur_disp = DS_PRINT;
            fp_tens  = DIGIT_W'(FP_TENS);
            fp_ones  = DIGIT_W'(FP_ONES);
         end
         ST_RUN: begin
            cur_disp = DS_MNEMONIC;
            cur_task = step_task(prog, int'(step));
         end
         default: ;
      endcase
   end

   assign task_code = cur_task;
   assign disp_sel  = cur_disp;
   assign lid_lock  = (phase != ST_IDLE);
   assign prog_id   = (phase == ST_IDLE) ? PG_NONE : prog;

endmodule

// File: rtl/wash_sequencer.sv
module wash_sequencer
   import wash_pkg::*;
#(
   parameter int FP_TENS  = 3,
   parameter int FP_ONES  = 6,
   parameter int SEL_MODE = 0,
   parameter int SEL_W    = 3,
   parameter int DIGIT_W  = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [2:0]   prog_sel,
   input  logic         lid_closed,
   input  logic         paid,
   output logic [2:0]   task_code,
   output logic         lid_lock,
   output logic [1:0]   disp_sel,
   output logic [1:0]   prog_id,
   output logic [3:0]   fp_tens,
   output logic [3:0]   fp_ones
);

   localparam int STEP_W = $clog2(MAX_STEPS);

   generate
      if (FP_TENS < 0 || FP_TENS > 9) begin : g_bad_tens
         $error("FP_TENS must be a decimal digit");
      end
      if (FP_ONES < 0 || FP_ONES > 9) begin : g_bad_ones
         $error("FP_ONES must be a decimal digit");
      end
      if (SEL_MODE != 0 && SEL_MODE != 1) begin : g_bad_mode
         $error("SEL_MODE must be 0 (strict one-hot) or 1 (priority)");
      end
      if (SEL_W != 3) begin : g_bad_sel
         $error("SEL_W must be 3, one switch per program");
      end
      if (DIGIT_W != 4) begin : g_bad_digit
         $error("DIGIT_W must be 4 for a BCD digit");
      end
   endgenerate

   logic              start;
   prog_e             start_prog;
   phase_e            phase;
   prog_e             prog;
   logic [STEP_W-1:0] step;

   wash_start_detect #(
      .SEL_W    (SEL_W),
      .SEL_MODE (SEL_MODE)
   ) start_i (
      .clk        (clk),
      .rst        (rst),
      .prog_sel   (prog_sel),
      .lid_closed (lid_closed),
      .paid       (paid),
      .start      (start),
      .start_prog (start_prog)
   );

   wash_step_ctrl #(
      .STEP_W (STEP_W)
   ) ctrl_i (
      .clk        (clk),
      .rst        (rst),
      .start      (start && (phase == ST_IDLE)),
      .start_prog (start_prog),
      .phase      (phase),
      .prog       (prog),
      .step       (step)
   );

   wash_out_map #(
      .STEP_W  (STEP_W),
      .DIGIT_W (DIGIT_W),
      .FP_TENS (FP_TENS),
      .FP_ONES (FP_ONES)
   ) map_i (
      .phase     (phase),
      .prog      (prog),
      .step      (step),
      .task_code (task_code),
      .lid_lock  (lid_lock),
      .disp_sel  (disp_sel),
      .prog_id   (prog_id),
      .fp_tens   (fp_tens),
      .fp_ones   (fp_ones)
   );

endmodule

// File: rtl/wash_sequencer_chk.sv
module wash_sequencer_chk (
   input logic       clk,
   input logic       rst,
   input logic [2:0] task_code,
   input logic       lid_lock,
   input logic [1:0] disp_sel,
   input logic [1:0] prog_id,
   input logic [3:0] fp_tens,
   input logic [3:0] fp_ones
);

   AST_UNLOCKED_IDLE: assert property (@(posedge clk) disable iff (rst)
      !lid_lock |-> (task_code == 3'd0 && disp_sel == 2'd0 && prog_id == 2'd0)); // R8

   AST_LOCK_STARTS_PRINT: assert property (@(posedge clk) disable iff (rst)
      $rose(lid_lock) |-> (disp_sel == 2'd1 && task_code == 3'd0)); // R3

   AST_PRINT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      (disp_sel == 2'd1) |=> (disp_sel == 2'd2 && task_code == 3'd1)); // R3

   AST_TASK_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
      (task_code != 3'd0) |-> (lid_lock && disp_sel == 2'd2)); // R7

   AST_SPIN_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
      (task_code == 3'd5) |=> !lid_lock); // R8

   AST_PROG_HELD: assert property (@(posedge clk) disable iff (rst)
      lid_lock |=> (!lid_lock || $stable(prog_id))); // R9

   AST_DIGITS_QUIET: assert property (@(posedge clk) disable iff (rst)
      (disp_sel != 2'd1) |-> (fp_tens == 4'd0 && fp_ones == 4'd0)); // R11

endmodule

bind wash_sequencer wash_sequencer_chk chk_i (
   .clk       (clk),
   .rst       (rst),
   .task_code (task_code),
   .lid_lock  (lid_lock),
   .disp_sel  (disp_sel),
   .prog_id   (prog_id),
   .fp_tens   (fp_tens),
   .fp_ones   (fp_ones)
);

// File: tb/wash_sequencer_tb_top.sv
module wash_sequencer_tb_top;

   localparam int TENS = 4;
   localparam int ONES = 7;

   logic       clk = 1'b0;
   logic       rst;
   logic [2:0] prog_sel;
   logic       lid_closed;
   logic       paid;
   logic [2:0] task_code;
   logic       lid_lock;
   logic [1:0] disp_sel;
   logic [1:0] prog_id;
   logic [3:0] fp_tens;
   logic [3:0] fp_ones;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;

   always #2 clk = ~clk;

   wash_sequencer #(.FP_TENS(TENS), .FP_ONES(ONES)) dut_i (
      .clk(clk), .rst(rst), .prog_sel(prog_sel), .lid_closed(lid_closed),
      .paid(paid), .task_code(task_code), .lid_lock(lid_lock),
      .disp_sel(disp_sel), .prog_id(prog_id), .fp_tens(fp_tens), .fp_ones(fp_ones)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [15:0] observed();
      return {task_code, lid_lock, disp_sel, prog_id, fp_tens, fp_ones};
   endfunction

   task automatic check(input string req, input logic [15:0] exp);
      logic [15:0] act;
      act = observed();
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // expected task code per program id and step, from R4/R5/R6
   function automatic logic [2:0] exp_task(input int pid, input int k);
      logic [2:0] b [4] = '{3'd1, 3'd2, 3'd4, 3'd5};
      logic [2:0] n [5] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5};
      logic [2:0] h [7] = '{3'd1, 3'd2, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5};
      case (pid)
         1:       return b[k];
         2:       return n[k];
         default: return h[k];
      endcase
   endfunction

   initial begin
      #(4 * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; prog_sel = 3'b001; lid_closed = 1'b0; paid = 1'b1;
      repeat (3) tick();
      check("R1 reset", 16'h0);
      rst = 1'b0;
      tick();
      check("R1/R11 after reset", 16'h0);

      for (int s = 0; s < 8; s++) begin
         for (int p = 0; p < 2; p++) begin
            int pid;
            int len;
            bit valid;
            pid   = (s == 1) ? 1 : (s == 2) ? 2 : (s == 4) ? 3 : 0;
            len   = (pid == 1) ? 4 : (pid == 2) ? 5 : 7;
            valid = (p == 1) && (pid != 0);

            lid_closed = 1'b0; prog_sel = 3'(s); paid = 1'(p);
            tick();
            check("R2 idle with lid open", 16'h0);

            lid_closed = 1'b1;
            tick();
            if (!valid) begin
               check("R2 no start", 16'h0);
               tick();
               check("R2/R11 still idle", 16'h0);
               continue;
            end
            check("R3 identification", {3'd0, 1'b1, 2'd1, 2'(pid), 4'(TENS), 4'(ONES)});

            for (int k = 0; k < len; k++) begin
               prog_sel   = 3'((s + k + 1) & 7);
               paid       = 1'(k & 1);
               lid_closed = (k == 1) ? 1'b0 : 1'b1;
               tick();
               if (pid == 1)
                  check("R4/R7/R9 basic step", {exp_task(pid, k), 1'b1, 2'd2, 2'(pid), 8'h0});
               else if (pid == 2)
                  check("R5/R7/R9 normal step", {exp_task(pid, k), 1'b1, 2'd2, 2'(pid), 8'h0});
               else
                  check("R6/R7/R9 heavy step", {exp_task(pid, k), 1'b1, 2'd2, 2'(pid), 8'h0});
            end

            lid_closed = 1'b1; paid = 1'b1; prog_sel = 3'b001;
            tick();
            check("R8 idle after spin", 16'h0);
            tick();
            check("R10 no restart", 16'h0);
            tick();
            check("R10/R11 no restart", 16'h0);
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule